// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Register Access

This block gathers a configurable number of level-sensitive interrupt lines, from 2 to 64, and drives one combined interrupt request. An APB slave port holds two per-source control words: an enable and a mask. Each is split into a low half for sources 0-31 and a high half for sources 32-63. A read-only status view shows which sources are active, enabled and not masked.

Control bits for sources beyond the configured count have no flip-flops behind them. They ignore writes and read as zero. Software can therefore learn the source count by writing all-ones to the enable words and finding the highest bit that reads back as set. The source inputs may come from other clock domains, so they pass through a two-stage synchronizer before any status logic.

Top module: `irq_aggr_apb`

## Requirements
- R1: The register map is enable-low at 0x00, enable-high at 0x04, mask-low at 0x08, mask-high at 0x0C, status-low at 0x30 and status-high at 0x34. A write to an enable or mask word in the APB access phase (psel_i, penable_i and pwrite_i all high) takes effect at that clock edge.
- R2: Source n uses bit n of the low words for n < 32, and bit n-32 of the high words for n >= 32.
- R3: Enable and mask bits at or above NUM_SRC ignore writes and read as 0. After all-ones is written to both enable words, the highest set bit across the {high, low} pair is bit NUM_SRC-1.
- R4: A mask bit of 1 blocks its source. A mask bit of 0 lets the source through.
- R5: Status bit n is the synchronized source n AND enable n AND NOT mask n. It follows the level of the source, and reading it does not clear it.
- R6: irq_o is high exactly when at least one status bit is set.
- R7: After reset, all enable bits and mask bits are 0 and irq_o is low.
- R8: Each source goes through two flip-flops. A change on src_i that is set up before clock edge k appears on irq_o and in status after edge k+1.
- R9: pready_o is always 1. An access to any offset outside the six defined registers raises pslverr_o in its access phase and reads 0. A write to such an offset changes no register.
- R10: A write to a status word changes neither the enable nor the mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write, 1 = write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pslverr_o | output | 1 | APB error for undefined offsets |
| src_i | input | NUM_SRC | Level interrupt sources |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the APB master follows the protocol: every access has one setup cycle followed by one access cycle, and the address and write data stay stable across both. They also assume that src_i is held low while reset is asserted. The bench drives every APB transfer through tasks that produce exactly this two-phase shape. It changes src_i only on falling clock edges, and only after reset has been released. Because of this, the synchronizer never captures a half-settled value, and each transfer sees one clean access phase.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned MAX_SRC = 64;

  localparam logic [7:0] OFF_EN_LO  = 8'h00;
  localparam logic [7:0] OFF_EN_HI  = 8'h04;
  localparam logic [7:0] OFF_MSK_LO = 8'h08;
  localparam logic [7:0] OFF_MSK_HI = 8'h0C;
  localparam logic [7:0] OFF_ST_LO  = 8'h30;
  localparam logic [7:0] OFF_ST_HI  = 8'h34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_LO,
    SEL_EN_HI,
    SEL_MSK_LO,
    SEL_MSK_HI,
    SEL_ST_LO,
    SEL_ST_HI
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_ctl_word.sv
// Holds one per-source control vector (enable or mask); only implemented bits own flops.
module irq_ctl_word
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [MAX_SRC-1:0] q_o
);
  localparam logic [MAX_SRC-1:0] IMPL =
    (NUM_SRC >= MAX_SRC) ? '1 : ((MAX_SRC'(1) << NUM_SRC) - MAX_SRC'(1));

  for (genvar i = 0; i < MAX_SRC; i++) begin : g_bit
    if (i < NUM_SRC) begin : g_flop
      localparam bit HI_HALF = (i >= WORD_W);
      logic bit_q;
      logic we;
      assign we = HI_HALF ? wr_hi_i : wr_lo_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  bit_q <= 1'b0;
        else if (we)  bit_q <= wdata_i[i % WORD_W];
      end
      assign q_o[i] = bit_q;
    end else begin : g_absent
      assign q_o[i] = 1'b0;
    end
  end

  AST_LO_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> q_o[WORD_W-1:0] == ($past(wdata_i) & IMPL[WORD_W-1:0])) else $error("lo write"); // R3
  AST_HI_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> q_o[MAX_SRC-1:WORD_W] == ($past(wdata_i) & IMPL[MAX_SRC-1:WORD_W])) else $error("hi write"); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> $stable(q_o)) else $error("unexpected change"); // R10
endmodule

// File: rtl/irq_aggr_apb.sv
module irq_aggr_apb
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [WORD_W-1:0]  pwdata_i,
  output logic [WORD_W-1:0]  prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_s;
  logic [MAX_SRC-1:0] src_w, en_q, msk_q, status;
  reg_sel_e           sel;
  logic               access, wr;

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_s)
  );

  always_comb begin
    unique case (paddr_i)
      ADDR_W'(OFF_EN_LO):  sel = SEL_EN_LO;
      ADDR_W'(OFF_EN_HI):  sel = SEL_EN_HI;
      ADDR_W'(OFF_MSK_LO): sel = SEL_MSK_LO;
      ADDR_W'(OFF_MSK_HI): sel = SEL_MSK_HI;
      ADDR_W'(OFF_ST_LO):  sel = SEL_ST_LO;
      ADDR_W'(OFF_ST_HI):  sel = SEL_ST_HI;
      default:             sel = SEL_NONE;
    endcase
  end

  assign access = psel_i & penable_i;
  assign wr     = access & pwrite_i;

  irq_ctl_word #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_lo_i(wr && sel == SEL_EN_LO),
    .wr_hi_i(wr && sel == SEL_EN_HI),
    .wdata_i(pwdata_i),
    .q_o    (en_q)
  );

  irq_ctl_word #(.NUM_SRC(NUM_SRC)) u_msk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_lo_i(wr && sel == SEL_MSK_LO),
    .wr_hi_i(wr && sel == SEL_MSK_HI),
    .wdata_i(pwdata_i),
    .q_o    (msk_q)
  );

  assign src_w  = MAX_SRC'(src_s);
  assign status = src_w & en_q & ~msk_q;
  assign irq_o  = |status;

  always_comb begin
    prdata_o = '0;
    if (psel_i) begin
      unique case (sel)
        SEL_EN_LO:  prdata_o = en_q[WORD_W-1:0];
        SEL_EN_HI:  prdata_o = en_q[MAX_SRC-1:WORD_W];
        SEL_MSK_LO: prdata_o = msk_q[WORD_W-1:0];
        SEL_MSK_HI: prdata_o = msk_q[MAX_SRC-1:WORD_W];
        SEL_ST_LO:  prdata_o = status[WORD_W-1:0];
        SEL_ST_HI:  prdata_o = status[MAX_SRC-1:WORD_W];
        default:    prdata_o = '0;
      endcase
    end
  end

  assign pready_o  = 1'b1;
  assign pslverr_o = access & (sel == SEL_NONE);

  AST_ERR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> prdata_o == '0) else $error("error data"); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |src_s) else $error("irq without source"); // R8
  AST_BLOCKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q & ~msk_q) == '0) |-> !irq_o) else $error("irq while blocked"); // R4
  AST_ST_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (sel == SEL_ST_LO || sel == SEL_ST_HI)) |=> ($stable(en_q) && $stable(msk_q)))
    else $error("status write changed state"); // R10
endmodule

// File: tb/irq_aggr_apb_test.sv
module irq_aggr_apb_test;
  localparam int    CLK_PERIOD = 10;
  localparam int    NUM_SRC    = 40;
  localparam int    ADDR_W     = 8;
  localparam longint unsigned IMPL =
    (NUM_SRC >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << NUM_SRC) - 64'd1);

  logic               clk = 0;
  logic               rst_n = 0;
  logic               psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0]  paddr = '0;
  logic [31:0]        pwdata = '0;
  logic [31:0]        prdata;
  logic               pready, pslverr, irq;
  logic [NUM_SRC-1:0] src = '0;

  int n_chk = 0;
  int n_fail = 0;

  longint unsigned m_en, m_msk, m_s1, m_s2;

  irq_aggr_apb #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .src_i(src), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_msk <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      m_s1 <= 64'(src);
      m_s2 <= m_s1;
      if (psel && penable && pwrite) begin
        case (paddr)
          8'h00: m_en  <= ((m_en  & 64'hFFFF_FFFF_0000_0000) | 64'(pwdata)) & IMPL;
          8'h04: m_en  <= ((m_en  & 64'h0000_0000_FFFF_FFFF) | (64'(pwdata) << 32)) & IMPL;
          8'h08: m_msk <= ((m_msk & 64'hFFFF_FFFF_0000_0000) | 64'(pwdata)) & IMPL;
          8'h0C: m_msk <= ((m_msk & 64'h0000_0000_FFFF_FFFF) | (64'(pwdata) << 32)) & IMPL;
          default: ;
        endcase
      end
    end
  end

  function automatic longint unsigned m_status();
    return m_s2 & m_en & ~m_msk;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    longint unsigned st = m_status();
    case (a)
      8'h00: return m_en[31:0];
      8'h04: return m_en[63:32];
      8'h08: return m_msk[31:0];
      8'h0C: return m_msk[63:32];
      8'h30: return st[31:0];
      8'h34: return st[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit m_bad(input logic [7:0] a);
    return !(a inside {8'h00, 8'h04, 8'h08, 8'h0C, 8'h30, 8'h34});
  endfunction

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock (R6, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq == (m_status() != 0), "R6/R8 irq_o", 64'(irq), 64'(m_status() != 0));
      chk(pready == 1'b1, "R9 pready_o", 64'(pready), 64'd1);
    end
  end

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    #1;
    chk(pslverr == m_bad(a), "R9 pslverr write", 64'(pslverr), 64'(m_bad(a)));
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] a, input string tag);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1;
    chk(prdata == m_read(a), tag, 64'(prdata), 64'(m_read(a)));
    chk(pslverr == m_bad(a), "R9 pslverr read", 64'(pslverr), 64'(m_bad(a)));
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic set_src(input logic [NUM_SRC-1:0] v);
    @(negedge clk);
    src = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    apb_read(8'h00, tag); apb_read(8'h04, tag);
    apb_read(8'h08, tag); apb_read(8'h0C, tag);
    apb_read(8'h30, tag); apb_read(8'h34, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7: reset state
    chk(irq == 1'b0, "R7 irq after reset", 64'(irq), 0);
    read_all("R7 reset value");

    // R3: probe source count
    apb_write(8'h00, 32'hFFFF_FFFF);
    apb_write(8'h04, 32'hFFFF_FFFF);
    apb_read(8'h00, "R3 probe enable lo");
    apb_read(8'h04, "R3 probe enable hi");
    @(negedge clk); psel = 1; paddr = 8'h04; penable = 1; #1;
    chk(prdata == 32'(IMPL >> 32), "R3 highest bit NUM_SRC-1", 64'(prdata), IMPL >> 32);
    chk(prdata[(NUM_SRC-1)%32] == 1'b1, "R3 top implemented bit", 64'(prdata), 1);
    @(negedge clk); psel = 0; penable = 0;

    // R4: mask all, sources active -> silent
    apb_write(8'h08, 32'hFFFF_FFFF);
    apb_write(8'h0C, 32'hFFFF_FFFF);
    apb_read(8'h0C, "R3 mask hi readback");
    set_src('1);
    chk(irq == 1'b0, "R4 all masked", 64'(irq), 0);
    apb_read(8'h30, "R4 status masked");

    // R5: unmask, status follows sources
    apb_write(8'h08, 32'h0);
    apb_write(8'h0C, 32'h0);
    set_src(NUM_SRC'(64'h0000_00A5_0000_1234));
    apb_read(8'h30, "R5 status lo");
    apb_read(8'h34, "R2 status hi");
    apb_read(8'h30, "R5 no clear on read");
    apb_write(8'h08, 32'h0000_FFFF);
    apb_read(8'h30, "R4 partial mask");

    // R10: status writes ignored
    apb_write(8'h30, 32'hFFFF_FFFF);
    apb_write(8'h34, 32'h0);
    read_all("R10 after status write");

    // R9: undefined offsets
    apb_read(8'h10, "R9 bad read zero");
    apb_write(8'h10, 32'h0);
    apb_write(8'h2C, 32'h0);
    read_all("R9 after bad write");

    // R2: only top source enabled
    apb_write(8'h00, 32'h0);
    apb_write(8'h04, 32'h1 << ((NUM_SRC-1) % 32));
    set_src(NUM_SRC'(1) << (NUM_SRC-1));
    chk(irq == 1'b1, "R2 top source irq", 64'(irq), 1);
    apb_read(8'h34, "R2 top status");

    // R8: latency after src change
    @(negedge clk); src = '0;
    @(negedge clk);
    chk(irq == 1'b1, "R8 still high after 1 edge", 64'(irq), 1);
    @(negedge clk);
    chk(irq == 1'b0, "R8 low after 2 edges", 64'(irq), 0);

    // R1/R5: toggling patterns
    apb_write(8'h00, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      set_src(NUM_SRC'(64'h1) << (k * 5));
      apb_read(8'h30, "R5 walk lo");
      apb_read(8'h34, "R5 walk hi");
    end
    apb_write(8'h00, 32'h0);
    apb_write(8'h04, 32'h0);
    set_src('1);
    chk(irq == 1'b0, "R6 nothing enabled", 64'(irq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule